// File: doc/BRIEF.md
# Branch Resolve and Flush Control

This block decides, for a five-stage 32-bit integer pipeline that always predicts fall-through, whether the fetch stream has to be redirected. Fetch keeps issuing sequential addresses without waiting for any branch. The block watches two points of the pipeline. In decode it resolves the equality branches (equal, not-equal) and direct jumps. In execute it resolves the magnitude branches (signed and unsigned less-than and greater-or-equal) and register-indirect jumps. When a redirect is due, it selects the new fetch address. It also tells the barrier registers that hold wrong-path instructions to load a do-nothing control bundle in place of their contents.

A redirect found in decode squashes only the fetch/decode barrier. A redirect found in execute squashes the fetch/decode and decode/execute barriers. Because a redirect in execute comes from the older instruction, it wins over anything decode resolves in the same cycle. While the hazard unit freezes the front end for a load-use hazard, decode resolution is suppressed, because its operands are not yet valid. A squash always beats a freeze on the same barrier.

Top module: `brc_top`

## Requirements
- R1: While `rst` is high, `taken_o`, `flush_ifid_o`, `flush_idex_o` and `hold_fetch_o` are 0, `pc_sel_o` is 2'b00 and `pc_target_o` is 0, whatever the other inputs are.
- R2: In decode, with `id_br_i`=1, funct3 3'b000 is taken when the operands are equal and 3'b001 is taken when they differ. A taken decode branch gives `pc_sel_o`=2'b01 and `pc_target_o`=`id_target_i`, and raises `flush_ifid_o` only. In a pipeline, a taken equal-branch followed by two adds lets neither add write a register.
- R3: In execute, with `ex_br_i`=1, funct3 3'b100/3'b101 are signed less-than/greater-or-equal and 3'b110/3'b111 are unsigned less-than/greater-or-equal. A taken execute branch gives `pc_sel_o`=2'b10 and `pc_target_o`=`ex_target_i`, and raises both `flush_ifid_o` and `flush_idex_o`.
- R4: Signed and unsigned compares are distinct: for operands 32'hFFFFFFFF and 1, code 3'b100 is taken and 3'b110 is not taken.
- R5: `id_jal_i`=1 is always taken in decode, with the same outputs as R2. `ex_jalr_i`=1 is always taken in execute, with the same outputs as R3.
- R6: Decode ignores branch codes with bit 2 set. Execute ignores branch codes with bit 2 clear. Codes 3'b010 and 3'b011 are never taken.
- R7: When decode and execute both call for a redirect in one cycle, execute wins: `pc_sel_o`=2'b10 and `pc_target_o`=`ex_target_i`.
- R8: While `stall_i`=1, decode resolves nothing, but execute still resolves.
- R9: `hold_fetch_o` equals `stall_i` except in a cycle with a redirect, where it is 0. A squash overrides a freeze.
- R10: `taken_o` is 1 exactly when a redirect is issued, and `flush_ifid_o` follows it. When no redirect is issued, `pc_sel_o` is 2'b00 and `pc_target_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Load-use freeze request from the hazard unit |
| id_br_i | input | 1 | Decode-stage instruction is a conditional branch |
| id_jal_i | input | 1 | Decode-stage instruction is a direct jump |
| id_funct3_i | input | 3 | Branch condition code in decode |
| id_op_a_i | input | XLEN | First operand in decode |
| id_op_b_i | input | XLEN | Second operand in decode |
| id_target_i | input | PC_W | Target address computed in decode |
| ex_br_i | input | 1 | Execute-stage instruction is a conditional branch |
| ex_jalr_i | input | 1 | Execute-stage instruction is a register-indirect jump |
| ex_funct3_i | input | 3 | Branch condition code in execute |
| ex_op_a_i | input | XLEN | First operand in execute |
| ex_op_b_i | input | XLEN | Second operand in execute |
| ex_target_i | input | PC_W | Target address computed in execute |
| taken_o | output | 1 | A redirect is issued this cycle |
| pc_sel_o | output | 2 | Next-PC source: 00 sequential, 01 decode target, 10 execute target |
| pc_target_o | output | PC_W | Selected redirect address (0 when sequential) |
| flush_ifid_o | output | 1 | Load a no-op bundle into the fetch/decode barrier |
| flush_idex_o | output | 1 | Load a no-op bundle into the decode/execute barrier |
| hold_fetch_o | output | 1 | Freeze the PC and the fetch/decode barrier |

## Verification
Two functions can fall in the same cycle: a load-use freeze and a squash of the same barrier. A second such pair is a decode redirect and an execute redirect. The bench provokes the first pair by raising the stall in the exact cycle a magnitude branch sits in execute. It provokes the second by placing a taken equal-branch in decode behind a taken jump in execute. In both cases it checks that the hold is dropped, that both barriers are squashed and that the execute target is chosen. In a behavioural pipeline model, it also checks that no squashed add ever reaches writeback.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    PCSEL_SEQ = 2'b00,
    PCSEL_ID  = 2'b01,
    PCSEL_EX  = 2'b10
  } pcsel_e;

  localparam logic [2:0] F3_EQ  = 3'b000;
  localparam logic [2:0] F3_NE  = 3'b001;
  localparam logic [2:0] F3_LT  = 3'b100;
  localparam logic [2:0] F3_GE  = 3'b101;
  localparam logic [2:0] F3_LTU = 3'b110;
  localparam logic [2:0] F3_GEU = 3'b111;
endpackage

// File: rtl/brc_cmp.sv
module brc_cmp #(
  parameter int XLEN = 32,
  parameter bit FULL = 1'b1
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            eq_o,
  output logic            lt_s_o,
  output logic            lt_u_o
);
  assign eq_o = (a_i == b_i);

  generate
    if (FULL) begin : g_mag
      assign lt_s_o = ($signed(a_i) < $signed(b_i));
      assign lt_u_o = (a_i < b_i);
    end else begin : g_eq_only
      assign lt_s_o = 1'b0;
      assign lt_u_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/brc_id_resolve.sv
module brc_id_resolve
  import brc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall_i,
  input  logic            br_i,
  input  logic            jal_i,
  input  logic [2:0]      f3_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            take_o
);
  logic eq;
  logic lt_s_unused;
  logic lt_u_unused;
  logic cond;

  brc_cmp #(.XLEN(XLEN), .FULL(1'b0)) u_cmp (
    .a_i    (a_i),
    .b_i    (b_i),
    .eq_o   (eq),
    .lt_s_o (lt_s_unused),
    .lt_u_o (lt_u_unused)
  );

  always_comb begin
    cond = 1'b0;
    if (br_i) begin
      unique case (f3_i)
        F3_EQ:   cond = eq;
        F3_NE:   cond = !eq;
        default: cond = 1'b0;
      endcase
    end
  end

  // Operands are not trustworthy during a load-use freeze.
  assign take_o = !stall_i && (cond || jal_i);

  AST_ID_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    stall_i |-> !take_o); // R8

  AST_ID_JAL_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (jal_i && !stall_i) |-> take_o); // R5

  AST_ID_MAG_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (f3_i[2] && !jal_i) |-> !take_o); // R6
endmodule

// File: rtl/brc_ex_resolve.sv
module brc_ex_resolve
  import brc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            br_i,
  input  logic            jalr_i,
  input  logic [2:0]      f3_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            take_o
);
  logic eq_unused;
  logic lt_s;
  logic lt_u;
  logic cond;

  brc_cmp #(.XLEN(XLEN), .FULL(1'b1)) u_cmp (
    .a_i    (a_i),
    .b_i    (b_i),
    .eq_o   (eq_unused),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  always_comb begin
    cond = 1'b0;
    if (br_i) begin
      unique case (f3_i)
        F3_LT:   cond = lt_s;
        F3_GE:   cond = !lt_s;
        F3_LTU:  cond = lt_u;
        F3_GEU:  cond = !lt_u;
        default: cond = 1'b0;
      endcase
    end
  end

  assign take_o = cond || jalr_i;

  AST_EX_JALR_TAKEN: assert property (@(posedge clk) disable iff (rst)
    jalr_i |-> take_o); // R5

  AST_EX_EQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!f3_i[2] && !jalr_i) |-> !take_o); // R6
endmodule

// File: rtl/brc_top.sv
module brc_top
  import brc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall_i,
  input  logic            id_br_i,
  input  logic            id_jal_i,
  input  logic [2:0]      id_funct3_i,
  input  logic [XLEN-1:0] id_op_a_i,
  input  logic [XLEN-1:0] id_op_b_i,
  input  logic [PC_W-1:0] id_target_i,
  input  logic            ex_br_i,
  input  logic            ex_jalr_i,
  input  logic [2:0]      ex_funct3_i,
  input  logic [XLEN-1:0] ex_op_a_i,
  input  logic [XLEN-1:0] ex_op_b_i,
  input  logic [PC_W-1:0] ex_target_i,
  output logic            taken_o,
  output logic [1:0]      pc_sel_o,
  output logic [PC_W-1:0] pc_target_o,
  output logic            flush_ifid_o,
  output logic            flush_idex_o,
  output logic            hold_fetch_o
);
  logic   id_take;
  logic   ex_take;
  logic   id_redir;
  logic   ex_redir;
  pcsel_e sel;

  brc_id_resolve #(.XLEN(XLEN)) u_id (
    .clk     (clk),
    .rst     (rst),
    .stall_i (stall_i),
    .br_i    (id_br_i),
    .jal_i   (id_jal_i),
    .f3_i    (id_funct3_i),
    .a_i     (id_op_a_i),
    .b_i     (id_op_b_i),
    .take_o  (id_take)
  );

  brc_ex_resolve #(.XLEN(XLEN)) u_ex (
    .clk    (clk),
    .rst    (rst),
    .br_i   (ex_br_i),
    .jalr_i (ex_jalr_i),
    .f3_i   (ex_funct3_i),
    .a_i    (ex_op_a_i),
    .b_i    (ex_op_b_i),
    .take_o (ex_take)
  );

  // The older instruction in execute overrides a younger decode redirect.
  assign ex_redir = !rst && ex_take;
  assign id_redir = !rst && id_take && !ex_take;

  always_comb begin
    sel         = PCSEL_SEQ;
    pc_target_o = '0;
    if (ex_redir) begin
      sel         = PCSEL_EX;
      pc_target_o = ex_target_i;
    end else if (id_redir) begin
      sel         = PCSEL_ID;
      pc_target_o = id_target_i;
    end
  end

  assign pc_sel_o     = sel;
  assign taken_o      = ex_redir || id_redir;
  assign flush_ifid_o = ex_redir || id_redir;
  assign flush_idex_o = ex_redir;
  assign hold_fetch_o = !rst && stall_i && !(ex_redir || id_redir);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (!taken_o && !flush_ifid_o && !flush_idex_o && !hold_fetch_o)); // R1

  AST_EX_FLUSHES_BOTH: assert property (@(posedge clk) disable iff (rst)
    flush_idex_o |-> (flush_ifid_o && pc_sel_o == PCSEL_EX)); // R3

  AST_EX_WINS: assert property (@(posedge clk) disable iff (rst)
    ex_take |-> (pc_sel_o == PCSEL_EX && pc_target_o == ex_target_i)); // R7

  AST_FLUSH_BEATS_HOLD: assert property (@(posedge clk) disable iff (rst)
    flush_ifid_o |-> !hold_fetch_o); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !ex_take) |-> hold_fetch_o); // R8
endmodule

// File: tb/brc_top_bench.sv
module brc_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int PC_W = 32;
  localparam int K_NOP = 0, K_ADD = 1, K_BR = 2, K_JAL = 3, K_JALR = 4;

  typedef struct {
    int          kind;
    logic [2:0]  f3;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] tgt;
    int          rd;
  } ins_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall_i = 1'b0;
  logic id_br_i = 1'b0, id_jal_i = 1'b0, ex_br_i = 1'b0, ex_jalr_i = 1'b0;
  logic [2:0] id_funct3_i = '0, ex_funct3_i = '0;
  logic [XLEN-1:0] id_op_a_i = '0, id_op_b_i = '0, ex_op_a_i = '0, ex_op_b_i = '0;
  logic [PC_W-1:0] id_target_i = '0, ex_target_i = '0;
  logic taken_o, flush_ifid_o, flush_idex_o, hold_fetch_o;
  logic [1:0] pc_sel_o;
  logic [PC_W-1:0] pc_target_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // expected values
  logic e_taken, e_fi, e_fx, e_hold;
  logic [1:0] e_sel;
  logic [31:0] e_tgt;

  ins_t prog [0:31];
  ins_t s_id, s_ex, s_mem, s_wb;
  int wr [0:7];
  logic [31:0] pc;

  brc_top #(.XLEN(XLEN), .PC_W(PC_W)) u_brc_top (
    .clk(clk), .rst(rst), .stall_i(stall_i),
    .id_br_i(id_br_i), .id_jal_i(id_jal_i), .id_funct3_i(id_funct3_i),
    .id_op_a_i(id_op_a_i), .id_op_b_i(id_op_b_i), .id_target_i(id_target_i),
    .ex_br_i(ex_br_i), .ex_jalr_i(ex_jalr_i), .ex_funct3_i(ex_funct3_i),
    .ex_op_a_i(ex_op_a_i), .ex_op_b_i(ex_op_b_i), .ex_target_i(ex_target_i),
    .taken_o(taken_o), .pc_sel_o(pc_sel_o), .pc_target_o(pc_target_o),
    .flush_ifid_o(flush_ifid_o), .flush_idex_o(flush_idex_o),
    .hold_fetch_o(hold_fetch_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic ins_t mk(int kind, logic [2:0] f3, logic [31:0] a,
                              logic [31:0] b, logic [31:0] tgt, int rd);
    ins_t r;
    r.kind = kind; r.f3 = f3; r.a = a; r.b = b; r.tgt = tgt; r.rd = rd;
    return r;
  endfunction

  // Reference: what the block must output for the inputs now being driven.
  task automatic model();
    logic id_t, ex_t, c;
    id_t = 1'b0; ex_t = 1'b0; c = 1'b0;
    if (id_br_i && id_funct3_i == 3'd0) id_t = (id_op_a_i == id_op_b_i);
    if (id_br_i && id_funct3_i == 3'd1) id_t = (id_op_a_i != id_op_b_i);
    if (id_jal_i) id_t = 1'b1;
    if (stall_i) id_t = 1'b0;
    case (ex_funct3_i)
      3'd4: c = ($signed(ex_op_a_i) < $signed(ex_op_b_i));
      3'd5: c = !($signed(ex_op_a_i) < $signed(ex_op_b_i));
      3'd6: c = (ex_op_a_i < ex_op_b_i);
      3'd7: c = !(ex_op_a_i < ex_op_b_i);
      default: c = 1'b0;
    endcase
    ex_t = ex_jalr_i || (ex_br_i && c);
    if (rst) begin id_t = 1'b0; ex_t = 1'b0; end
    e_taken = id_t || ex_t;
    e_sel   = ex_t ? 2'b10 : (id_t ? 2'b01 : 2'b00);
    e_tgt   = ex_t ? ex_target_i : (id_t ? id_target_i : 32'd0);
    e_fi    = e_taken;
    e_fx    = ex_t;
    e_hold  = !rst && stall_i && !e_taken;
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string ctx);
    model();
    chk(taken_o == e_taken, {"R10 taken ", ctx}, 32'(taken_o), 32'(e_taken));
    chk(pc_sel_o == e_sel, {"R7 pc_sel ", ctx}, 32'(pc_sel_o), 32'(e_sel));
    chk(pc_target_o == e_tgt, {"R5 target ", ctx}, pc_target_o, e_tgt);
    chk(flush_ifid_o == e_fi, {"R2 flush_ifid ", ctx}, 32'(flush_ifid_o), 32'(e_fi));
    chk(flush_idex_o == e_fx, {"R3 flush_idex ", ctx}, 32'(flush_idex_o), 32'(e_fx));
    chk(hold_fetch_o == e_hold, {"R9 hold ", ctx}, 32'(hold_fetch_o), 32'(e_hold));
  endtask

  task automatic drive_slots(ins_t id, ins_t ex, logic st);
    stall_i     = st;
    id_br_i     = (id.kind == K_BR);  id_jal_i  = (id.kind == K_JAL);
    id_funct3_i = id.f3; id_op_a_i = id.a; id_op_b_i = id.b; id_target_i = id.tgt;
    ex_br_i     = (ex.kind == K_BR);  ex_jalr_i = (ex.kind == K_JALR);
    ex_funct3_i = ex.f3; ex_op_a_i = ex.a; ex_op_b_i = ex.b; ex_target_i = ex.tgt;
  endtask

  task automatic vec(string ctx, ins_t id, ins_t ex, logic st);
    @(negedge clk);
    drive_slots(id, ex, st);
    #1;
    compare(ctx);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) prog[i] = mk(K_NOP, 3'd0, 0, 0, 0, 0);
  endtask

  // Behavioural pipeline: fetch, decode, execute, memory, writeback.
  task automatic run_prog(string ctx, int ncyc, logic [63:0] stall_mask);
    ins_t nop, f;
    nop = mk(K_NOP, 3'd0, 0, 0, 0, 0);
    s_id = nop; s_ex = nop; s_mem = nop; s_wb = nop; pc = 0;
    for (int i = 0; i < 8; i++) wr[i] = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      drive_slots(s_id, s_ex, stall_mask[c]);
      #1;
      compare(ctx);
      f = (pc[31:2] < 32) ? prog[pc[6:2]] : nop;
      s_wb = s_mem;
      s_mem = s_ex;
      if (e_fx) begin
        pc = e_tgt; s_ex = nop; s_id = nop;
      end else if (e_fi) begin
        pc = e_tgt; s_ex = s_id; s_id = nop;
      end else if (e_hold) begin
        s_ex = nop;
      end else begin
        s_ex = s_id; s_id = f; pc = pc + 4;
      end
      if (s_wb.kind == K_ADD) wr[s_wb.rd]++;
    end
  endtask

  initial begin
    ins_t nop;
    nop = mk(K_NOP, 3'd0, 0, 0, 0, 0);

    // R1: reset silences everything even with redirects offered
    vec("R1 reset", mk(K_JAL, 3'd0, 0, 0, 32'h100, 0),
        mk(K_JALR, 3'd0, 0, 0, 32'h200, 0), 1'b1);
    @(negedge clk); rst = 1'b0;

    // R2 equality in decode
    vec("R2 beq eq", mk(K_BR, 3'd0, 5, 5, 32'h40, 0), nop, 1'b0);
    vec("R2 beq ne", mk(K_BR, 3'd0, 5, 6, 32'h40, 0), nop, 1'b0);
    vec("R2 bne ne", mk(K_BR, 3'd1, 5, 6, 32'h44, 0), nop, 1'b0);
    vec("R2 bne eq", mk(K_BR, 3'd1, 7, 7, 32'h44, 0), nop, 1'b0);
    // R3 / R4 magnitude in execute, signed vs unsigned
    vec("R4 blt -1<1", nop, mk(K_BR, 3'd4, 32'hFFFFFFFF, 1, 32'h80, 0), 1'b0);
    vec("R4 bltu -1<1", nop, mk(K_BR, 3'd6, 32'hFFFFFFFF, 1, 32'h80, 0), 1'b0);
    vec("R3 bge eq", nop, mk(K_BR, 3'd5, 9, 9, 32'h84, 0), 1'b0);
    vec("R3 bgeu big", nop, mk(K_BR, 3'd7, 32'hFFFFFFFF, 1, 32'h88, 0), 1'b0);
    vec("R3 bge neg", nop, mk(K_BR, 3'd5, 32'h80000000, 0, 32'h8C, 0), 1'b0);
    // R5 jumps
    vec("R5 jal", mk(K_JAL, 3'd0, 0, 0, 32'h300, 0), nop, 1'b0);
    vec("R5 jalr", nop, mk(K_JALR, 3'd0, 0, 0, 32'h304, 0), 1'b0);
    // R6 wrong-stage codes and unused codes are ignored
    vec("R6 id mag", mk(K_BR, 3'd4, 32'hFFFFFFFF, 1, 32'h50, 0), nop, 1'b0);
    vec("R6 ex eq", nop, mk(K_BR, 3'd0, 3, 3, 32'h54, 0), 1'b0);
    vec("R6 ex 010", nop, mk(K_BR, 3'd2, 0, 1, 32'h58, 0), 1'b0);
    vec("R6 id 011", mk(K_BR, 3'd3, 0, 1, 32'h5C, 0), nop, 1'b0);
    // R7 both redirect: execute wins
    vec("R7 both", mk(K_BR, 3'd0, 1, 1, 32'h60, 0),
        mk(K_JALR, 3'd0, 0, 0, 32'h64, 0), 1'b0);
    // R8 stall suppresses decode only
    vec("R8 stall id", mk(K_BR, 3'd0, 2, 2, 32'h68, 0), nop, 1'b1);
    vec("R8 stall ex", mk(K_BR, 3'd0, 2, 2, 32'h68, 0),
        mk(K_BR, 3'd4, 0, 1, 32'h6C, 0), 1'b1);
    // R9 flush beats hold
    vec("R9 hold vs flush", nop, mk(K_JALR, 3'd0, 0, 0, 32'h70, 0), 1'b1);

    // R2: taken BEQ followed by two adds; neither add may write
    clear_prog();
    prog[0]  = mk(K_BR, 3'd0, 4, 4, 32'h40, 0);
    prog[1]  = mk(K_ADD, 3'd0, 0, 0, 0, 1);
    prog[2]  = mk(K_ADD, 3'd0, 0, 0, 0, 2);
    prog[16] = mk(K_ADD, 3'd0, 0, 0, 0, 3);
    run_prog("beq pipe", 10, 64'd0);
    chk(wr[1] == 0, "R2 add1 squashed", wr[1], 0);
    chk(wr[2] == 0, "R2 add2 squashed", wr[2], 0);
    chk(wr[3] == 1, "R2 target add", wr[3], 1);

    // R3: taken signed BLT with stalls in decode and during resolve
    clear_prog();
    prog[0]  = mk(K_BR, 3'd4, 32'hFFFFFFFF, 1, 32'h40, 0);
    prog[1]  = mk(K_ADD, 3'd0, 0, 0, 0, 1);
    prog[2]  = mk(K_ADD, 3'd0, 0, 0, 0, 2);
    prog[16] = mk(K_ADD, 3'd0, 0, 0, 0, 3);
    run_prog("blt pipe", 12, 64'b1010);
    chk(wr[1] == 0, "R3 add1 squashed", wr[1], 0);
    chk(wr[2] == 0, "R3 add2 squashed", wr[2], 0);
    chk(wr[3] == 1, "R3 target add", wr[3], 1);

    // R4: same operands unsigned, not taken, adds retire
    clear_prog();
    prog[0] = mk(K_BR, 3'd6, 32'hFFFFFFFF, 1, 32'h40, 0);
    prog[1] = mk(K_ADD, 3'd0, 0, 0, 0, 1);
    prog[2] = mk(K_ADD, 3'd0, 0, 0, 0, 2);
    run_prog("bltu pipe", 10, 64'd0);
    chk(wr[1] == 1, "R4 add1 retires", wr[1], 1);
    chk(wr[2] == 1, "R4 add2 retires", wr[2], 1);

    // R7: jalr in execute behind which a taken beq sits in decode
    clear_prog();
    prog[0]  = mk(K_JALR, 3'd0, 0, 0, 32'h40, 0);
    prog[1]  = mk(K_BR, 3'd0, 1, 1, 32'h20, 0);
    prog[8]  = mk(K_ADD, 3'd0, 0, 0, 0, 4);
    prog[16] = mk(K_ADD, 3'd0, 0, 0, 0, 5);
    run_prog("jalr pipe", 10, 64'd0);
    chk(wr[4] == 0, "R7 younger beq squashed", wr[4], 0);
    chk(wr[5] == 1, "R7 jalr target reached", wr[5], 1);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule